// File: doc/BRIEF.md
# Two-Bit-Per-Clock Carry-Save Distributed-Arithmetic Dot Product

This block forms the signed dot product of four n-bit two's-complement samples with four constant signed coefficients, fixed at elaboration. It uses no multiplier. Each clock, two bit positions of every sample are consumed. The even-position bits of the four samples form the address of one partial-sum table, and the odd-position bits form the address of a second, identical table. Both tables hold every subset sum of the four coefficients. The odd table's output is weighted one bit above the even table's output. Both enter a carry-save accumulator that shifts right by two positions per clock and releases two finished low result bits each clock.

Inside the main loop no carry runs across the word. Each bit cell keeps its own sum bit and its own carry bit. A carry produced at one position is registered and then arrives at the cell one place below it after the two-position shift. On the final loop clock the odd table reads the sign-bit row, so its output is inverted, and the matching increment is not added there. After the loop, one pass sums the residual sum and carry vectors. A second pass removes a constant fixed at elaboration, which covers both that postponed increment and the bias that keeps table entries non-negative. This gives the exact signed result.

A user loads the four samples with a one-clock `start` and waits for the one-clock `done`. The result register keeps its value until the next completion.

Top module: `da2_mac`

## Requirements
- R1: `result` equals C0·x0 + C1·x1 + C2·x2 + C3·x3, exact, as an N_BITS+CW+2-bit two's-complement value. The samples are signed N_BITS-bit values and the coefficients are signed parameters of CW bits.
- R2: `done` is high for exactly one clock. It rises N_BITS/2+1 rising edges after the edge that accepted `start`, so a sampler working one clock apart sees it on the (N_BITS/2+2)-th sample after driving `start`.
- R3: Samples are read only on the edge that accepts `start`. Changes to `x0_in`..`x3_in` after that edge do not alter the result.
- R4: `start` raised while a computation is in progress is ignored. Neither the running result nor the timing of `done` changes.
- R5: Between completions, `result` holds its last value.
- R6: Synchronous active-high `rst` clears `done` to 0 and `result` to 0 and leaves the block idle.
- R7: Extreme samples (−2^(N_BITS−1) and 2^(N_BITS−1)−1) give exact results, with bit N_BITS−1 weighted as −2^(N_BITS−1).
- R8: A `start` sampled on the edge at which `done` is high is accepted, so operations can run back to back without a gap.
- R9: N_BITS must be even and at least 4. The accumulation loop takes N_BITS/2 clocks, plus one clock for the final resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a computation with the present samples when idle |
| x0_in | input | N_BITS | Signed sample paired with C0 |
| x1_in | input | N_BITS | Signed sample paired with C1 |
| x2_in | input | N_BITS | Signed sample paired with C2 |
| x3_in | input | N_BITS | Signed sample paired with C3 |
| done | output | 1 | One-clock pulse when `result` is updated |
| result | output | N_BITS+CW+2 | Signed dot product |

## Verification
The accumulator bound assertion takes for granted that every table entry stays below 2^(CW+2). That only holds if each coefficient fits in CW signed bits, and the bench chooses its coefficients to meet this. The timing assertions take for granted that `start` arrives only while the block is idle or is meant to be ignored. The stimulus therefore includes starts raised deliberately in mid-run, starts raised on the `done` edge, and sample changes right after acceptance, and it checks these cases against a reference model that changes state only on edges where it accepts a start.

// File: rtl/da2_pkg.sv
package da2_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } da2_state_e;

    // Subset sum of the four coefficients chosen by a 4-bit row address.
    function automatic int da2_partial(input logic [3:0] sel,
                                       input int c0, input int c1,
                                       input int c2, input int c3);
        int acc;
        acc = 0;
        if (sel[0]) acc = acc + c0;
        if (sel[1]) acc = acc + c1;
        if (sel[2]) acc = acc + c2;
        if (sel[3]) acc = acc + c3;
        return acc;
    endfunction

    // Constant removed after the loop: per-entry bias on every step, plus the
    // inverted sign row (all-ones minus bias) standing in for the negated one.
    function automatic longint unsigned da2_comp(input int unsigned n_bits,
                                                 input int unsigned tw,
                                                 input int unsigned cw);
        longint unsigned steps, p, q, b, top;
        steps = longint'(n_bits / 2);
        p     = 64'd1 << (2 * steps);
        q     = p >> 2;
        b     = 64'd1 << (cw + 1);
        top   = (64'd1 << tw) - 64'd1 - b;
        return (b * (p - 64'd1)) / 64'd3 + (64'd2 * b * (q - 64'd1)) / 64'd3
               + 64'd2 * top * q;
    endfunction

endpackage

// File: rtl/da2_table.sv
module da2_table
    import da2_pkg::*;
#(
    parameter int CW = 8,
    parameter int TW = CW + 2,
    parameter int C0 = 1,
    parameter int C1 = 1,
    parameter int C2 = 1,
    parameter int C3 = 1
) (
    input  logic [3:0]    sel,
    input  logic          flip,
    output logic [TW-1:0] val
);
    localparam int BIAS = 1 << (CW + 1);

    logic [TW-1:0] rom [16];

    generate
        for (genvar a = 0; a < 16; a++) begin : g_ent
            localparam int ENTRY = da2_partial(4'(a), C0, C1, C2, C3) + BIAS;
            assign rom[a] = TW'(ENTRY);
        end
    endgenerate

    assign val = flip ? ~rom[sel] : rom[sel];

endmodule

// File: rtl/da2_csa_acc.sv
module da2_csa_acc #(
    parameter int TW = 10,
    parameter int AW = TW + 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    input  logic [TW-1:0] even_v,
    input  logic [TW-1:0] odd_v,
    output logic [1:0]    emit,
    output logic [AW-1:0] sum_q,
    output logic [AW-1:0] car_q,
    output logic          hold_q
);
    logic [AW-1:0] op_e, op_o, s1, m1, c1, s2, m2, c2;
    logic [2:0]    low;

    // Two 3:2 compressor rows per cell; no carry crosses a cell here.
    always_comb begin
        op_e = AW'(even_v);
        op_o = AW'({odd_v, 1'b0});
        s1   = sum_q ^ car_q ^ op_e;
        m1   = (sum_q & car_q) | (sum_q & op_e) | (car_q & op_e);
        c1   = (m1 << 1) | AW'(hold_q);
        s2   = s1 ^ c1 ^ op_o;
        m2   = (s1 & c1) | (s1 & op_o) | (c1 & op_o);
        c2   = m2 << 1;
        low  = {1'b0, s2[1:0]} + {1'b0, c2[1:0]};
        emit = low[1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sum_q  <= '0;
            car_q  <= '0;
            hold_q <= 1'b0;
        end else if (step) begin
            sum_q  <= s2 >> 2;
            car_q  <= c2 >> 2;
            hold_q <= low[2];
        end
    end

    localparam logic [AW+1:0] LIM = (AW+2)'(1) << (TW + 1);

    // R1: stored residue stays inside the headroom so no top carry is lost.
    p_acc_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (({2'b0, sum_q} + {2'b0, car_q} + (AW+2)'(hold_q)) < LIM));

endmodule

// File: rtl/da2_mac.sv
module da2_mac
    import da2_pkg::*;
#(
    parameter int N_BITS = 12,
    parameter int CW     = 8,
    parameter int C0     = 57,
    parameter int C1     = -128,
    parameter int C2     = 127,
    parameter int C3     = -3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [N_BITS-1:0]      x0_in,
    input  logic [N_BITS-1:0]      x1_in,
    input  logic [N_BITS-1:0]      x2_in,
    input  logic [N_BITS-1:0]      x3_in,
    output logic                   done,
    output logic [N_BITS+CW+1:0]   result
);
    localparam int STEPS = N_BITS / 2;
    localparam int CNT_W = $clog2(STEPS);
    localparam int TW    = CW + 2;
    localparam int AW    = TW + 3;
    localparam int RW    = N_BITS + CW + 2;
    localparam int VW    = N_BITS + AW + 1;
    localparam logic [VW-1:0] K_COMP =
        VW'(da2_comp(N_BITS, TW, CW));

    da2_state_e             state;
    logic [CNT_W-1:0]       cnt;
    logic [3:0][N_BITS-1:0] xr;
    logic [N_BITS-1:0]      lo;
    logic [3:0]             sel_ev, sel_od;
    logic [TW-1:0]          tab_v [2];
    logic                   last;
    logic [1:0]             emit;
    logic [AW-1:0]          sum_q, car_q;
    logic                   hold_q;
    logic [AW:0]            hi;
    logic [VW-1:0]          full;

    assign last = (cnt == CNT_W'(STEPS - 1));

    generate
        for (genvar k = 0; k < 4; k++) begin : g_lane
            assign sel_ev[k] = xr[k][0];
            assign sel_od[k] = xr[k][1];
        end
        for (genvar t = 0; t < 2; t++) begin : g_tab
            da2_table #(.CW(CW), .TW(TW), .C0(C0), .C1(C1), .C2(C2), .C3(C3)) u_tab (
                .sel  ((t == 0) ? sel_ev : sel_od),
                .flip ((t == 1) ? last : 1'b0),
                .val  (tab_v[t])
            );
        end
    endgenerate

    da2_csa_acc #(.TW(TW), .AW(AW)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clear  (state == ST_IDLE && start),
        .step   (state == ST_RUN),
        .even_v (tab_v[0]),
        .odd_v  (tab_v[1]),
        .emit   (emit),
        .sum_q  (sum_q),
        .car_q  (car_q),
        .hold_q (hold_q)
    );

    // Final resolution: one pass over the residue, one pass removing the constant.
    always_comb begin
        hi   = {1'b0, sum_q} + {1'b0, car_q} + (AW+1)'(hold_q);
        full = {hi, lo};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            xr     <= '0;
            lo     <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    xr    <= {x3_in, x2_in, x1_in, x0_in};
                    cnt   <= '0;
                    state <= ST_RUN;
                end
                ST_RUN: begin
                    for (int k = 0; k < 4; k++) xr[k] <= xr[k] >> 2;
                    lo  <= {emit, lo[N_BITS-1:2]};
                    cnt <= cnt + 1'b1;
                    if (last) state <= ST_FIN;
                end
                ST_FIN: begin
                    result <= RW'(full - K_COMP);
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_after_fin_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state == ST_FIN));
    p_cnt_range_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (cnt < CNT_W'(STEPS)));
    p_busy_ignores_start_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && start) |=> (state != ST_IDLE));
    p_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

endmodule

// File: tb/da2_mac_bench.sv
module da2_mac_bench;
    localparam int NB  = 12;
    localparam int CWB = 8;
    localparam int K0  = 57;
    localparam int K1  = -128;
    localparam int K2  = 127;
    localparam int K3  = -3;
    localparam int RWB = NB + CWB + 2;
    localparam int LB  = NB / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic signed [NB-1:0] xa = '0, xb = '0, xc = '0, xd = '0;
    logic done;
    logic [RWB-1:0] result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    da2_mac #(.N_BITS(NB), .CW(CWB), .C0(K0), .C1(K1), .C2(K2), .C3(K3)) u_da2_mac (
        .clk(clk), .rst(rst), .start(start),
        .x0_in(xa), .x1_in(xb), .x2_in(xc), .x3_in(xd),
        .done(done), .result(result)
    );

    function automatic longint ref_dot(longint a, longint b, longint c, longint d);
        return longint'(K0) * a + longint'(K1) * b + longint'(K2) * c + longint'(K3) * d;
    endfunction

    // Behavioural model: countdown from the accepted start, result latched at done.
    int             m_cnt = 0;
    logic           m_done = 1'b0;
    logic [RWB-1:0] m_res = '0;
    logic [RWB-1:0] m_pend = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt  = 0;
            m_done = 1'b0;
            m_res  = '0;
        end else if (m_cnt > 0) begin
            m_cnt  = m_cnt - 1;
            m_done = (m_cnt == 0);
            if (m_cnt == 0) m_res = m_pend;
        end else begin
            m_done = 1'b0;
            if (start) begin
                m_cnt  = LB + 1;
                m_pend = RWB'(ref_dot(longint'(xa), longint'(xb), longint'(xc), longint'(xd)));
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2 done", 64'(done), 64'(m_done));
            chk(m_done ? "R1 result" : "R5 result", 64'(result), 64'(m_res));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // One operation: optional immediate launch, scrambled inputs after the
    // accepting edge (R3), optional mid-run start pulse (R4), latency check (R2).
    task automatic run_op(input logic signed [NB-1:0] a, b, c, d,
                          input bit now, input bit poke, input string tag);
        logic [RWB-1:0] e;
        int waited;
        e = RWB'(ref_dot(longint'(a), longint'(b), longint'(c), longint'(d)));
        if (!now) @(negedge clk);
        xa = a; xb = b; xc = c; xd = d; start = 1'b1;
        @(negedge clk);
        waited = 1;
        start = 1'b0;
        xa = NB'($urandom); xb = NB'($urandom); xc = NB'($urandom); xd = NB'($urandom);
        if (poke) begin
            @(negedge clk);
            waited++;
            start = 1'b1;
            xa = NB'($urandom); xb = NB'($urandom);
            @(negedge clk);
            waited++;
            start = 1'b0;
        end
        while (!done && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        chk(tag, 64'(result), 64'(e));
        chk("R2 latency", 64'(waited), 64'(LB + 2));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 done", 64'(done), 64'd0);
        chk("R6 result", 64'(result), 64'd0);

        run_op(12'sd5, 12'sd3, -12'sd7, 12'sd100, 1'b0, 1'b0, "R1 basic");
        run_op(-12'sd2048, -12'sd2048, -12'sd2048, -12'sd2048, 1'b0, 1'b0, "R7 all min");
        run_op(12'sd2047, 12'sd2047, 12'sd2047, 12'sd2047, 1'b0, 1'b0, "R7 all max");
        run_op(-12'sd2048, 12'sd2047, -12'sd2048, 12'sd2047, 1'b0, 1'b0, "R7 mixed");
        run_op(12'sd0, 12'sd0, 12'sd0, 12'sd0, 1'b0, 1'b0, "R1 zero");
        run_op(-12'sd1, 12'sd1, -12'sd1, 12'sd1, 1'b0, 1'b0, "R1 unit");
        run_op(12'sd321, -12'sd999, 12'sd17, -12'sd600, 1'b0, 1'b1, "R4 mid-run start");
        run_op(12'sd44, 12'sd55, -12'sd66, 12'sd77, 1'b0, 1'b0, "R3 inputs changed");
        run_op(-12'sd2048, 12'sd1, 12'sd2047, -12'sd1, 1'b1, 1'b0, "R8 back to back");
        run_op(12'sd700, -12'sd2048, 12'sd3, 12'sd2047, 1'b1, 1'b0, "R8 back to back 2");

        for (int i = 0; i < 30; i++) begin
            run_op(NB'($urandom), NB'($urandom), NB'($urandom), NB'($urandom),
                   (i % 3) == 2, (i % 5) == 4, "R1 random");
        end

        repeat (4) @(negedge clk);
        chk("R5 hold", 64'(result), 64'(m_res));
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 reset done", 64'(done), 64'd0);
        chk("R6 reset result", 64'(result), 64'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule